// File: doc/BRIEF.md
# Colour Lookup Table Port

This block holds a 256-entry colour table. Each entry carries a 6-bit red, green and blue value. A host reaches the table through four byte-wide registers. Two index registers set where a walk starts: one for writes and one for reads. One data port is shared by reads and writes. A mask register gates the pixel index. Every data-port access moves one component. The next component is chosen by a three-state phase machine:

- `PH_RED` goes to `PH_GRN` (ADVANCE).
- `PH_GRN` goes to `PH_BLU` (ADVANCE).
- `PH_BLU` goes back to `PH_RED` (WRAP). This step also moves the active index to the next entry, and index 255 rolls to 0.
- A write to either index register returns the machine to `PH_RED` from any state (RESTART).

A separate pixel port runs on the same clock. It takes an 8-bit pixel index, ANDs it with the mask, and returns the three components of that entry one clock later. If a host write lands on the same entry and component in the same cycle, the pixel port returns the new value. Analog conversion is outside this block.

Register map, selected by `host_addr`:

| Address | Register |
|---|---|
| 0 | Write index |
| 1 | Data port |
| 2 | Read index |
| 3 | Pixel mask |

A data-port read is counted only when `host_we` is low, so a write wins if both strobes are raised together.

Top module: `clut_port`

## Requirements
- R1: After reset, the write index and read index read 0, the mask reads 0xFF, the phase is red, every table component is 0 and the pixel outputs are 0.
- R2: Writing address 3 sets the mask, and reading address 3 returns it. Reading addresses 0 and 2 returns the write index and read index, and such reads change neither.
- R3: Three successive data-port writes (address 1) store red, green and blue, in that order, into the entry at the write index. After the blue write, the write index goes up by one.
- R4: Three successive data-port reads (address 1, `host_we` low) return red, green and blue, in that order, of the entry at the read index, on `host_rdata` in the cycle the read strobe is high. After the blue read, the read index goes up by one.
- R5: Writing either index register (address 0 or 2) returns the component phase to red, even in the middle of a triplet.
- R6: Both indices wrap from 255 to 0. After 256 complete triplets written from index 0, the write index reads 0.
- R7: Only data bits 5:0 are stored. Data-port reads return 0 on bits 7:6.
- R8: The pixel outputs show the entry at (`pix_idx` AND mask) one clock after `pix_idx` is presented. A mask of 0xFF leaves the index unchanged.
- R9: A host write to the entry and component that the pixel port is looking up in the same cycle appears on the pixel output at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register select: 0 write index, 1 data, 2 read index, 3 mask |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe; a data-port read advances the phase |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the selected register (combinational) |
| pix_idx | input | 8 | Pixel index before masking |
| pix_red | output | 6 | Red component, one clock after the index |
| pix_grn | output | 6 | Green component, one clock after the index |
| pix_blu | output | 6 | Blue component, one clock after the index |

## Verification
The hardest situations to reach from the ports are a restart in the middle of a triplet and a pixel lookup that collides with a host write. For the restart, the stimulus writes one red component, then rewrites the write index to a different entry. It then checks that the next three bytes go to the new entry starting at red. For reads, it does the same by rewriting the read index after two component reads. For the collision, the stimulus raises a data-port write and a pixel lookup of the same entry in the same cycle. The expected pixel value is the freshly written red, together with the unchanged green and blue.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int IDX_W  = 8;
    localparam int COMP_W = 6;
    localparam int BUS_W  = 8;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    localparam logic [1:0] A_WIDX = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_RIDX = 2'd2;
    localparam logic [1:0] A_MASK = 2'd3;

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          widx_wr,
    input  logic          ridx_wr,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic [IW-1:0] idx_val,
    output phase_e        phase,
    output logic [IW-1:0] widx,
    output logic [IW-1:0] ridx
);

    phase_e        phase_q, phase_d;
    logic [IW-1:0] widx_q, widx_d;
    logic [IW-1:0] ridx_q, ridx_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
            widx_q  <= '0;
            ridx_q  <= '0;
        end else begin
            phase_q <= phase_d;
            widx_q  <= widx_d;
            ridx_q  <= ridx_d;
        end
    end

    // next state: RESTART, ADVANCE, WRAP
    always_comb begin
        phase_d = phase_q;
        widx_d  = widx_q;
        ridx_d  = ridx_q;
        if (widx_wr) begin
            widx_d  = idx_val;
            phase_d = PH_RED;
        end else if (ridx_wr) begin
            ridx_d  = idx_val;
            phase_d = PH_RED;
        end else if (data_wr || data_rd) begin
            unique case (phase_q)
                PH_RED: phase_d = PH_GRN;
                PH_GRN: phase_d = PH_BLU;
                PH_BLU: begin
                    phase_d = PH_RED;
                    if (data_wr) widx_d = widx_q + 1'b1;
                    else         ridx_d = ridx_q + 1'b1;
                end
                default: phase_d = PH_RED;
            endcase
        end
    end

    assign phase = phase_q;
    assign widx  = widx_q;
    assign ridx  = ridx_q;

    p_widx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !widx_wr && !ridx_wr && phase_q == PH_BLU) |=> (widx_q == $past(widx_q) + 1'b1));

    p_phase_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (widx_wr || ridx_wr) |=> (phase_q == PH_RED));

    p_ridx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_rd && !ridx_wr) |=> $stable(ridx_q));

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int CW = COMP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  phase_e              wr_comp,
    input  logic [IW-1:0]       wr_idx,
    input  logic [CW-1:0]       wr_val,
    input  logic [IW-1:0]       rd_idx,
    output logic [2:0][CW-1:0]  rd_val,
    input  logic [IW-1:0]       pix_idx,
    output logic [2:0][CW-1:0]  pix_val
);

    localparam int DEPTH = 1 << IW;

    for (genvar c = 0; c < 3; c++) begin : g_comp
        logic [CW-1:0] mem [DEPTH];
        logic [CW-1:0] pix_q;
        logic          hit;

        assign hit = wr_en && (wr_comp == phase_e'(c));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (hit) begin
                mem[wr_idx] <= wr_val;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)                        pix_q <= '0;
            else if (hit && wr_idx == pix_idx) pix_q <= wr_val;
            else                               pix_q <= mem[pix_idx];
        end

        assign rd_val[c]  = mem[rd_idx];
        assign pix_val[c] = pix_q;
    end

    p_pix_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_comp == PH_RED && wr_idx == pix_idx) |=> (pix_val[0] == $past(wr_val)));

endmodule

// File: rtl/clut_port.sv
module clut_port
    import clut_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int CW = COMP_W,
    parameter int BW = BUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    host_addr,
    input  logic          host_we,
    input  logic          host_re,
    input  logic [BW-1:0] host_wdata,
    output logic [BW-1:0] host_rdata,
    input  logic [IW-1:0] pix_idx,
    output logic [CW-1:0] pix_red,
    output logic [CW-1:0] pix_grn,
    output logic [CW-1:0] pix_blu
);

    logic              widx_wr, ridx_wr, data_wr, data_rd, mask_wr;
    phase_e            phase;
    logic [IW-1:0]     widx, ridx;
    logic [IW-1:0]     mask_q;
    logic [2:0][CW-1:0] rd_val, pix_val;
    logic [CW-1:0]     rd_comp;

    assign widx_wr = host_we && host_addr == A_WIDX;
    assign ridx_wr = host_we && host_addr == A_RIDX;
    assign mask_wr = host_we && host_addr == A_MASK;
    assign data_wr = host_we && host_addr == A_DATA;
    assign data_rd = host_re && !host_we && host_addr == A_DATA;

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= host_wdata[IW-1:0];
    end

    clut_seq #(.IW(IW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .widx_wr (widx_wr),
        .ridx_wr (ridx_wr),
        .data_wr (data_wr),
        .data_rd (data_rd),
        .idx_val (host_wdata[IW-1:0]),
        .phase   (phase),
        .widx    (widx),
        .ridx    (ridx)
    );

    clut_store #(.IW(IW), .CW(CW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (data_wr),
        .wr_comp (phase),
        .wr_idx  (widx),
        .wr_val  (host_wdata[CW-1:0]),
        .rd_idx  (ridx),
        .rd_val  (rd_val),
        .pix_idx (pix_idx & mask_q),
        .pix_val (pix_val)
    );

    always_comb begin
        unique case (phase)
            PH_GRN:  rd_comp = rd_val[1];
            PH_BLU:  rd_comp = rd_val[2];
            default: rd_comp = rd_val[0];
        endcase
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            A_WIDX:  host_rdata[IW-1:0] = widx;
            A_DATA:  host_rdata[CW-1:0] = rd_comp;
            A_RIDX:  host_rdata[IW-1:0] = ridx;
            default: host_rdata[IW-1:0] = mask_q;
        endcase
    end

    assign pix_red = pix_val[0];
    assign pix_grn = pix_val[1];
    assign pix_blu = pix_val[2];

    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));

endmodule

// File: tb/clut_port_test.sv
module clut_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic       host_we = 1'b0;
    logic       host_re = 1'b0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic [7:0] pix_idx = 8'd0;
    logic [5:0] pix_red, pix_grn, pix_blu;

    always #10 clk = ~clk;

    clut_port uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
        .host_re(host_re), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_idx(pix_idx), .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu)
    );

    int checks = 0;
    int errors = 0;

    // requirement model
    logic [5:0] m_r [256];
    logic [5:0] m_g [256];
    logic [5:0] m_b [256];
    int         m_w = 0, m_rd = 0, m_ph = 0;
    logic [7:0] m_mask = 8'hFF;

    // scoreboard queues
    logic [7:0]  hq [$];
    string       hq_tag [$];
    logic [17:0] pq [$];
    string       pq_tag [$];
    logic        pix_vld = 1'b0;
    logic        pv_d = 1'b0;

    always @(posedge clk) pv_d <= pix_vld;

    always @(negedge clk) begin
        if (host_re && hq.size() > 0) begin
            logic [7:0] e;
            string t;
            e = hq.pop_front();
            t = hq_tag.pop_front();
            checks++;
            if (host_rdata !== e) begin
                errors++;
                $display("FAIL %s host_rdata actual %h expected %h", t, host_rdata, e);
            end
        end
        if (pv_d && pq.size() > 0) begin
            logic [17:0] e;
            string t;
            e = pq.pop_front();
            t = pq_tag.pop_front();
            checks++;
            if ({pix_red, pix_grn, pix_blu} !== e) begin
                errors++;
                $display("FAIL %s pixel actual %h expected %h", t, {pix_red, pix_grn, pix_blu}, e);
            end
        end
    end

    function automatic void model_wr(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'd0: begin m_w = d; m_ph = 0; end
            2'd1: begin
                if (m_ph == 0) m_r[m_w] = d[5:0];
                else if (m_ph == 1) m_g[m_w] = d[5:0];
                else begin m_b[m_w] = d[5:0]; m_w = (m_w + 1) % 256; end
                m_ph = (m_ph + 1) % 3;
            end
            2'd2: begin m_rd = d; m_ph = 0; end
            default: m_mask = d;
        endcase
    endfunction

    function automatic logic [17:0] model_pix(input logic [7:0] idx);
        logic [7:0] k;
        k = idx & m_mask;
        return {m_r[k], m_g[k], m_b[k]};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        host_addr = a; host_wdata = d; host_we = 1'b1;
        model_wr(a, d);
        @(posedge clk); #1;
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        logic [7:0] e;
        @(posedge clk); #1;
        case (a)
            2'd0: e = 8'(m_w);
            2'd1: begin
                if (m_ph == 0) e = {2'b00, m_r[m_rd]};
                else if (m_ph == 1) e = {2'b00, m_g[m_rd]};
                else begin e = {2'b00, m_b[m_rd]}; m_rd = (m_rd + 1) % 256; end
                m_ph = (m_ph + 1) % 3;
            end
            2'd2: e = 8'(m_rd);
            default: e = m_mask;
        endcase
        hq.push_back(e); hq_tag.push_back(tag);
        host_addr = a; host_re = 1'b1;
        @(posedge clk); #1;
        host_re = 1'b0;
    endtask

    task automatic pix(input logic [7:0] idx, input string tag);
        @(posedge clk); #1;
        pix_idx = idx; pix_vld = 1'b1;
        pq.push_back(model_pix(idx)); pq_tag.push_back(tag);
        @(posedge clk); #1;
        pix_vld = 1'b0;
    endtask

    // data write and pixel lookup in the same cycle
    task automatic wr_pix(input logic [7:0] d, input logic [7:0] idx, input string tag);
        @(posedge clk); #1;
        host_addr = 2'd1; host_wdata = d; host_we = 1'b1;
        pix_idx = idx; pix_vld = 1'b1;
        model_wr(2'd1, d);
        pq.push_back(model_pix(idx)); pq_tag.push_back(tag);
        @(posedge clk); #1;
        host_we = 1'b0; pix_vld = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin m_r[i] = 0; m_g[i] = 0; m_b[i] = 0; end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(2'd0, "R1");
        rd(2'd2, "R1");
        rd(2'd3, "R1");
        pix(8'd5, "R1");
        rd(2'd1, "R1");

        // R3, R6, R7: fill all 256 entries, upper bits set
        wr(2'd0, 8'd0);
        for (int i = 0; i < 256; i++) begin
            wr(2'd1, 8'hC0 | 8'(i & 63));
            wr(2'd1, 8'h80 | 8'((i * 5) & 63));
            wr(2'd1, 8'h40 | 8'((255 - i) & 63));
        end
        rd(2'd0, "R6");

        // R4, R6, R7: read across the wrap
        wr(2'd2, 8'd250);
        for (int i = 0; i < 10; i++) begin
            rd(2'd1, "R4");
            rd(2'd1, "R7");
            rd(2'd1, "R4");
        end
        rd(2'd2, "R6");
        rd(2'd0, "R2");

        // R5: restart mid-triplet on writes and reads
        wr(2'd0, 8'd10);
        wr(2'd1, 8'h11);
        wr(2'd0, 8'd20);
        wr(2'd1, 8'd1);
        wr(2'd1, 8'd2);
        wr(2'd1, 8'd3);
        rd(2'd0, "R3");
        wr(2'd2, 8'd10);
        rd(2'd1, "R5");
        rd(2'd1, "R5");
        wr(2'd2, 8'd20);
        rd(2'd1, "R5");
        rd(2'd1, "R5");
        rd(2'd1, "R5");
        rd(2'd2, "R4");

        // R8: pixel lookups, then masked
        pix(8'd0, "R8");
        pix(8'd200, "R8");
        pix(8'd255, "R8");
        wr(2'd3, 8'h0F);
        rd(2'd3, "R2");
        pix(8'hF3, "R8");
        pix(8'h5A, "R8");
        wr(2'd3, 8'hFF);
        pix(8'h5A, "R8");

        // R9: host write collides with pixel lookup
        wr(2'd0, 8'd40);
        wr_pix(8'h2A, 8'd40, "R9");
        pix(8'd40, "R9");

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule